// File: doc/BRIEF.md
# Chained serial configuration node

This block sits at one position in a chain of serially configured nodes that share a single data path. A composite bitstream arrives one bit per rising edge of the configuration clock. The stream holds a start pattern, a 24-bit total length, each node's program in turn, a trailer, and filler bits. The node first looks for the start pattern and reads the length. It then takes the next `OWN_BITS` bits as its own program and hands every bit after that to the next node. This continues until the number of bits received matches the length.

While it takes in its own program, the serial output stays high, so downstream nodes see only idle ones. The start pattern and the length field are passed on, so each downstream node can frame the stream the same way. Bits are sampled on the rising clock edge. The output is driven on the falling edge, so the next node can sample it on its own rising edge. The captured program is presented in parallel with a one-cycle strobe. Two level flags report that the node's program is loaded and that the whole chain stream is finished.

Top module: `cfg_chain_node`

## Requirements
- R1: While reset is held and in the cycle after it is released, `dout` is 1 and `own_done`, `chain_done` and `own_valid` are 0.
- R2: Before the start pattern is recognised, each bit sampled on `din` appears on `dout` at the next falling edge. The start pattern is the 8-bit sequence 1,1,1,1,0,0,1,0 in arrival order. It is recognised on the edge that samples its last bit, even when it follows any run of ones or a near-miss sequence.
- R3: The 24 bits after the start pattern form the total length, most significant bit first. They are forwarded on `dout` like the pattern bits. The running total counts the 8 pattern bits and the 24 length bits.
- R4: For the `OWN_BITS` bits after the length field, `dout` stays 1 whatever `din` carries.
- R5: The first program bit lands in `own_data[OWN_BITS-1]` and the last one in bit 0. On the edge that samples the last program bit, `own_valid` pulses for exactly one cycle and `own_done` rises and stays high.
- R6: After the program, each further bit is forwarded on `dout` until the running total equals the length. The bit that reaches the length is itself forwarded, and `chain_done` rises on the edge that samples it.
- R7: Once `chain_done` is high it stays high. Later `din` bits are ignored and `dout` stays 1 until reset.
- R8: `dout` changes only on falling clock edges: its value just after a rising edge equals its value just before it.
- R9: If the total reaches the length before the program is complete, `chain_done` rises on that edge and the remaining program bits are not taken. `own_done` and `own_valid` stay 0. This includes a length equal to the header size, which ends the stream on the last length bit.
- R10: A reset in the middle of a stream clears every flag and counter, drives `dout` high and returns the node to looking for the start pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; `din` sampled on rising edge, `dout` driven on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial stream in |
| dout | output | 1 | Serial stream to the next node |
| own_done | output | 1 | High once this node's program is fully captured |
| chain_done | output | 1 | High once the received total equals the length field |
| own_valid | output | 1 | One-cycle strobe when `own_data` becomes complete |
| own_data | output | OWN_BITS | Captured program, first bit in the MSB |

## Verification
The bench builds the node with `OWN_BITS` = 12 and keeps the 24-bit length field. A short program lets small lengths such as 32, 40, 45 and 54 place the end of the stream at chosen points: on the last length bit, inside the program, on the first surplus bit, or after several surplus bits. The same setting makes a reset partway through the program quick to reach. The bench then reruns a stream with no leading ones to confirm that pattern search starts cleanly again.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

    localparam int          HDR_PAT_W   = 8;
    localparam logic [7:0]  HDR_PAT     = 8'b1111_0010;
    localparam int          TOTAL_W_DEF = 24;

    typedef enum logic [2:0] {
        ST_SEEK = 3'd0,
        ST_LEN  = 3'd1,
        ST_OWN  = 3'd2,
        ST_PASS = 3'd3,
        ST_DONE = 3'd4
    } node_st_e;

    // Phases in which the sampled bit is handed to the next node.
    function automatic logic st_forwards(node_st_e s);
        return (s == ST_SEEK) || (s == ST_LEN) || (s == ST_PASS);
    endfunction

endpackage

// File: rtl/cfgc_hdr.sv
module cfgc_hdr #(
    parameter int          PAT_W = 8,
    parameter logic [PAT_W-1:0] PAT = 8'b1111_0010,
    parameter int          LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seek_en,
    input  logic             len_en,
    input  logic             din,
    output logic             pat_hit,
    output logic             len_last,
    output logic [LEN_W-1:0] len_word
);
    localparam int IDX_W = $clog2(LEN_W);

    logic [PAT_W-2:0] pat_sh;
    logic [LEN_W-2:0] len_sh;
    logic [IDX_W-1:0] len_idx;

    assign len_word = {len_sh, din};
    assign pat_hit  = seek_en && ({pat_sh, din} == PAT);
    assign len_last = len_en && (len_idx == IDX_W'(LEN_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_sh  <= '0;
            len_sh  <= '0;
            len_idx <= '0;
        end else begin
            if (seek_en) begin
                pat_sh <= {pat_sh[PAT_W-3:0], din};
            end
            if (len_en) begin
                len_sh  <= len_word[LEN_W-2:0];
                len_idx <= len_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgc_own_store.sv
module cfgc_own_store #(
    parameter int OWN_BITS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_en,
    input  logic                din,
    output logic                own_last,
    output logic                valid,
    output logic [OWN_BITS-1:0] store
);
    localparam int IDX_W = (OWN_BITS > 1) ? $clog2(OWN_BITS) : 1;

    logic [IDX_W-1:0] idx;

    assign own_last = cap_en && (idx == IDX_W'(OWN_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
            idx   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= own_last;
            if (cap_en) begin
                store <= {store[OWN_BITS-2:0], din};
                idx   <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgc_fwd_out.sv
module cfgc_fwd_out (
    input  logic clk,
    input  logic rst,
    input  logic pass_en,
    input  logic din,
    output logic dout
);
    logic stage;

    // Rising edge: take the bit to forward, or an idle one.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= 1'b1;
        end else begin
            stage <= pass_en ? din : 1'b1;
        end
    end

    // Falling edge: present it to the next node.
    always_ff @(negedge clk) begin
        if (rst) begin
            dout <= 1'b1;
        end else begin
            dout <= stage;
        end
    end
endmodule

// File: rtl/cfg_chain_node.sv
module cfg_chain_node
    import cfgc_pkg::*;
#(
    parameter int OWN_BITS = 64,
    parameter int LEN_W    = cfgc_pkg::TOTAL_W_DEF,
    parameter int PAT_W    = cfgc_pkg::HDR_PAT_W
) (
    input  logic                cclk,
    input  logic                rst,
    input  logic                din,
    output logic                dout,
    output logic                own_done,
    output logic                chain_done,
    output logic                own_valid,
    output logic [OWN_BITS-1:0] own_data
);
    node_st_e         st;
    logic [LEN_W-1:0] total;
    logic [LEN_W-1:0] total_inc;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_word;
    logic             pat_hit;
    logic             len_last;
    logic             own_last;

    assign total_inc = total + 1'b1;

    cfgc_hdr #(
        .PAT_W (PAT_W),
        .PAT   (HDR_PAT),
        .LEN_W (LEN_W)
    ) u_hdr (
        .clk      (cclk),
        .rst      (rst),
        .seek_en  (st == ST_SEEK),
        .len_en   (st == ST_LEN),
        .din      (din),
        .pat_hit  (pat_hit),
        .len_last (len_last),
        .len_word (len_word)
    );

    cfgc_own_store #(
        .OWN_BITS (OWN_BITS)
    ) u_store (
        .clk      (cclk),
        .rst      (rst),
        .cap_en   (st == ST_OWN),
        .din      (din),
        .own_last (own_last),
        .valid    (own_valid),
        .store    (own_data)
    );

    cfgc_fwd_out u_out (
        .clk     (cclk),
        .rst     (rst),
        .pass_en (st_forwards(st)),
        .din     (din),
        .dout    (dout)
    );

    always_ff @(posedge cclk) begin
        if (rst) begin
            st         <= ST_SEEK;
            total      <= '0;
            len_q      <= '0;
            own_done   <= 1'b0;
            chain_done <= 1'b0;
        end else begin
            unique case (st)
                ST_SEEK: begin
                    if (pat_hit) begin
                        total <= LEN_W'(PAT_W);
                        st    <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    total <= total_inc;
                    if (len_last) begin
                        len_q <= len_word;
                        if (len_word <= total_inc) begin
                            chain_done <= 1'b1;
                            st         <= ST_DONE;
                        end else begin
                            st <= ST_OWN;
                        end
                    end
                end
                ST_OWN: begin
                    total <= total_inc;
                    if (own_last) begin
                        own_done <= 1'b1;
                    end
                    if (total_inc >= len_q) begin
                        chain_done <= 1'b1;
                        st         <= ST_DONE;
                    end else if (own_last) begin
                        st <= ST_PASS;
                    end
                end
                ST_PASS: begin
                    total <= total_inc;
                    if (total_inc >= len_q) begin
                        chain_done <= 1'b1;
                        st         <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    st <= ST_DONE;
                end
                default: st <= ST_SEEK;
            endcase
        end
    end
endmodule

// File: rtl/cfg_chain_node_chk.sv
module cfg_chain_node_chk
    import cfgc_pkg::*;
(
    input logic     cclk,
    input logic     rst,
    input logic     din,
    input logic     dout,
    input logic     own_done,
    input logic     chain_done,
    input logic     own_valid,
    input node_st_e st
);
    // R2
    r2_seek_fwd_chk: assert property (@(posedge cclk) disable iff (rst)
        (st == ST_SEEK) |=> (dout == $past(din)));

    // R4
    r4_own_hold_chk: assert property (@(posedge cclk) disable iff (rst)
        (st == ST_OWN) |=> dout);

    // R6
    r6_pass_fwd_chk: assert property (@(posedge cclk) disable iff (rst)
        (st == ST_PASS) |=> (dout == $past(din)));

    // R5
    r5_valid_pulse_chk: assert property (@(posedge cclk) disable iff (rst)
        own_valid |=> !own_valid);

    // R5
    r5_valid_done_chk: assert property (@(posedge cclk) disable iff (rst)
        own_valid |-> own_done);

    // R5
    r5_own_sticky_chk: assert property (@(posedge cclk) disable iff (rst)
        own_done |=> own_done);

    // R7
    r7_chain_sticky_chk: assert property (@(posedge cclk) disable iff (rst)
        chain_done |=> chain_done);

    // R7
    r7_done_quiet_chk: assert property (@(posedge cclk) disable iff (rst)
        (chain_done && $past(chain_done)) |-> dout);

    // R9
    r9_no_late_valid_chk: assert property (@(posedge cclk) disable iff (rst)
        $past(chain_done) |-> !own_valid);
endmodule

bind cfg_chain_node cfg_chain_node_chk u_chk (
    .cclk       (cclk),
    .rst        (rst),
    .din        (din),
    .dout       (dout),
    .own_done   (own_done),
    .chain_done (chain_done),
    .own_valid  (own_valid),
    .st         (st)
);

// File: tb/cfg_chain_node_bench.sv
`timescale 1ns/1ps
module cfg_chain_node_bench;
    localparam int         OWN = 12;
    localparam logic [7:0] PAT = 8'b1111_0010;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           din = 1'b1;
    logic           dout, own_done, chain_done, own_valid;
    logic [OWN-1:0] own_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int since_rst = 0;
    logic late_dout = 1'b1;
    logic [OWN-1:0] exp_dat = '0;
    bit finished = 0;

    typedef struct {
        int    due;
        logic  ed, eo, ec, ev;
        string tag;
    } item_t;
    item_t exp_q[$];
    item_t cur;

    always #2.5 clk = ~clk;

    cfg_chain_node #(.OWN_BITS(OWN)) u_cfg_chain_node (
        .cclk(clk), .rst(rst), .din(din), .dout(dout),
        .own_done(own_done), .chain_done(chain_done),
        .own_valid(own_valid), .own_data(own_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        since_rst <= rst ? 0 : since_rst + 1;
    end

    // Monitor: pop expected items when their cycle comes due.
    always @(posedge clk) begin
        #4;
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            cur = exp_q.pop_front();
            check({cur.tag, " dout"},       dout,       cur.ed);
            check({cur.tag, " own_done"},   own_done,   cur.eo);
            check({cur.tag, " chain_done"}, chain_done, cur.ec);
            check({cur.tag, " own_valid"},  own_valid,  cur.ev);
            if (cur.ev) check("R5 own_data", own_data, exp_dat);
        end
    end

    // R8: dout must not move at the rising edge.
    always @(posedge clk) begin
        #1;
        if (since_rst >= 2 && !rst) check("R8 dout at rising edge", dout, late_dout);
        #3;
        late_dout = dout;
    end

    task automatic drive(input logic b, input logic ed, input logic eo,
                         input logic ec, input logic ev, input string tag);
        @(posedge clk);
        #1;
        din = b;
        exp_q.push_back('{cyc + 1, ed, eo, ec, ev, tag});
    endtask

    task automatic do_reset(input string tag);
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b1;
        din = 1'b1;
        @(posedge clk);
        #4;
        check({tag, " dout in reset"}, dout, 1'b1);
        check({tag, " flags in reset"}, {own_done, chain_done, own_valid}, 3'b000);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #4;
        check({tag, " dout after reset"}, dout, 1'b1);
        check({tag, " flags after reset"}, {own_done, chain_done, own_valid}, 3'b000);
    endtask

    task automatic run_stream(input logic [31:0] noise, input int n_noise,
                              input logic [23:0] len, input logic [OWN-1:0] own,
                              input logic [31:0] pass, input int n_pass,
                              input int n_body);
        int   t;
        int   oi;
        bit   done;
        bit   eo;
        bit   v;
        logic b;
        exp_dat = own;
        for (int i = n_noise - 1; i >= 0; i--) drive(noise[i], noise[i], 0, 0, 0, "R2");
        for (int i = 7; i >= 0; i--) drive(PAT[i], PAT[i], 0, 0, 0, "R2");
        t = 8; done = 0; eo = 0; oi = 0;
        for (int i = 23; i >= 0; i--) begin
            t++;
            if (i == 0 && int'(len) <= t) done = 1;
            drive(len[i], len[i], 0, done, 0, done ? "R9" : "R3");
        end
        for (int i = 0; i < n_body; i++) begin
            if (i < OWN) b = own[OWN-1-i];
            else if (i < OWN + n_pass) b = pass[n_pass-1-(i-OWN)];
            else b = 1'b0;
            if (done) begin
                drive(b, 1'b1, eo, 1'b1, 0, "R7");
            end else begin
                t++;
                if (oi < OWN) begin
                    oi++;
                    v = (oi == OWN);
                    if (v) eo = 1;
                    if (t >= int'(len)) done = 1;
                    drive(b, 1'b1, eo, done, v, (done && !v) ? "R9" : (v ? "R5" : "R4"));
                end else begin
                    if (t >= int'(len)) done = 1;
                    drive(b, b, eo, done, 0, "R6");
                end
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        check("R1 dout in reset", dout, 1'b1);
        check("R1 flags in reset", {own_done, chain_done, own_valid}, 3'b000);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #4;
        check("R1 dout after reset", dout, 1'b1);
        check("R1 flags after reset", {own_done, chain_done, own_valid}, 3'b000);

        // Near-miss noise, full program, ten surplus bits, trailing fill ignored.
        run_stream(32'b1111_0011_1111, 12, 24'd54, 12'hA5C, 32'b10_1100_1110, 10, 28);
        do_reset("R10");

        // Length equals header size: stream ends on last length bit.
        run_stream(32'b111, 3, 24'd32, 12'hFFF, 32'd0, 0, 4);
        do_reset("R10");

        // Length ends inside the program.
        run_stream(32'b1, 1, 24'd40, 12'h0F0, 32'd0, 0, 12);
        do_reset("R10");

        // Abort partway through the program.
        run_stream(32'b11, 2, 24'd54, 12'h123, 32'd0, 0, 5);
        do_reset("R10");

        // No leading ones; one surplus bit of value 0, then fill.
        run_stream(32'd0, 0, 24'd45, 12'h3C1, 32'b0, 1, 16);
        repeat (3) @(posedge clk);
        #4;
        check("R7 chain_done held", chain_done, 1'b1);
        check("R7 dout idle", dout, 1'b1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule